// File: doc/BRIEF.md
# Signed-Digit Coefficient Term Generator

This block computes the weighted contribution of one filter tap without a multiplier. The tap coefficient is written as up to three signed power-of-two digits. Each digit is described by a 5-bit code that is held in a register: the low four bits give a right-shift distance and the top bit asks for a negated term. The sample is first widened to an extended internal width. That width adds fraction guard bits below the sample LSB, which limit truncation loss, and headroom bits above it. Each code then turns the widened sample into one signed partial product.

The three partial products come out separately, so a shared compression tree can absorb them. When the `SUM_EN` parameter is set, the block also adds them into a single tap value at the same width. All three codes load together on a load strobe. The terms follow the sample combinationally, so a new sample shows on the outputs in the same cycle.

Top module: `sdterm_gen`

## Requirements
- R1: After an asynchronous active-low reset, all three held codes are 5'b01111, so every term and the sum read 0.
- R2: The widened sample is W = smp * 2^FB, with smp read as signed. For a held code with bit 4 = 0 and low nibble k in 0..14, the term is floor(W / 2^k), an arithmetic right shift. Code 5'b00000 gives W itself.
- R3: For a held code with bit 4 = 1 and low nibble k in 0..14, the term is -floor(W / 2^k), negated in two's complement at the term width. Code 5'b10000 gives -W.
- R4: A held code whose low nibble is 4'b1111 gives a term of 0, whatever bit 4 holds.
- R5: When ld is low at a rising clock edge, the held codes keep their values. Changes on code0..code2 have no effect on the terms.
- R6: When ld is high at a rising clock edge, all three codes are captured at that edge. From that cycle on, term0, term1 and term2 follow code0, code1 and code2 respectively.
- R7: With SUM_EN = 1, tap_sum equals term0 + term1 + term2 exactly, for every sample and code. The width TW = DW + FB + HB with HB = 2 cannot overflow.
- R8: The terms and the sum follow smp combinationally, in the same cycle, with no register on the sample path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld | input | 1 | Load strobe that captures all three codes |
| code0 | input | 5 | Digit code for term0 |
| code1 | input | 5 | Digit code for term1 |
| code2 | input | 5 | Digit code for term2 |
| smp | input | DW | Signed data sample |
| term0 | output | TW | Signed partial product from held code 0 |
| term1 | output | TW | Signed partial product from held code 1 |
| term2 | output | TW | Signed partial product from held code 2 |
| tap_sum | output | TW | Sum of the three terms, or 0 when SUM_EN = 0 |

## Verification
The bench drives the most negative and most positive samples through a shift of 0 with negation. A design that widened the sample too little would wrap here, turning a large positive term negative. It also uses negative samples at large shifts, where a logical shift would fill ones-to-zeros and return a large positive value instead of -1. Codes 5'b01111 and 5'b11111 are both applied to check that the sign bit cannot turn a forced zero into something else. Code inputs are changed while the strobe is low, which catches a register that loads on every cycle, and each strobe loads three different codes, which catches lanes that are crossed or loaded one at a time.

// File: rtl/sdterm_gen.sv
module sdterm_gen #(
  parameter int DW = 10,
  parameter int FB = 4,
  parameter int HB = 2,
  parameter bit SUM_EN = 1'b1,
  localparam int TW = DW + FB + HB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic [4:0]           code0,
  input  logic [4:0]           code1,
  input  logic [4:0]           code2,
  input  logic signed [DW-1:0] smp,
  output logic signed [TW-1:0] term0,
  output logic signed [TW-1:0] term1,
  output logic signed [TW-1:0] term2,
  output logic signed [TW-1:0] tap_sum
);
  localparam int NT = 3;
  localparam logic [4:0] ZCODE = 5'b01111;

  logic [4:0] cd_in [NT];
  logic [4:0] cd_q  [NT];
  logic signed [TW-1:0] base;
  logic signed [TW-1:0] t [NT];

  assign cd_in[0] = code0;
  assign cd_in[1] = code1;
  assign cd_in[2] = code2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) cd_q[i] <= ZCODE;
    end else if (ld) begin
      for (int i = 0; i < NT; i++) cd_q[i] <= cd_in[i];
    end
  end

  assign base = {{HB{smp[DW-1]}}, smp, {FB{1'b0}}};

  for (genvar g = 0; g < NT; g++) begin : g_lane
    logic signed [TW-1:0] sh;
    assign sh   = base >>> cd_q[g][3:0];
    assign t[g] = (&cd_q[g][3:0]) ? '0 : (cd_q[g][4] ? -sh : sh);
  end

  assign term0 = t[0];
  assign term1 = t[1];
  assign term2 = t[2];

  if (SUM_EN) begin : g_sum
    assign tap_sum = t[0] + t[1] + t[2];
  end else begin : g_nosum
    assign tap_sum = '0;
  end
endmodule

// File: rtl/sdterm_gen_chk.sv
module sdterm_gen_chk #(
  parameter int DW = 10,
  parameter int FB = 4,
  parameter int HB = 2,
  parameter bit SUM_EN = 1'b1,
  localparam int TW = DW + FB + HB
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ld,
  input logic [4:0]           code0,
  input logic [4:0]           code1,
  input logic [4:0]           code2,
  input logic signed [DW-1:0] smp,
  input logic signed [TW-1:0] term0,
  input logic signed [TW-1:0] term1,
  input logic signed [TW-1:0] term2,
  input logic signed [TW-1:0] tap_sum
);
  logic signed [TW-1:0] wide;
  assign wide = {{HB{smp[DW-1]}}, smp, {FB{1'b0}}};

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld && code0 == 5'b00000 |=> term0 == wide);

  p_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld && code1 == 5'b10000 |=> term1 == -wide);

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld && code2[3:0] == 4'b1111 |=> term2 == '0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ($stable(smp) -> ($stable(term0) && $stable(term1) && $stable(term2))));

  if (SUM_EN) begin : g_sumchk
    p_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld && code0 == 5'b00000 && code1 == 5'b00000 && code2 == 5'b11111
      |=> tap_sum == (wide <<< 1));
  end
endmodule

bind sdterm_gen sdterm_gen_chk #(.DW(DW), .FB(FB), .HB(HB), .SUM_EN(SUM_EN)) u_chk (.*);

// File: tb/sim_sdterm_gen.sv
module sim_sdterm_gen;
  localparam int DW = 10;
  localparam int FB = 4;
  localparam int HB = 2;
  localparam int TW = DW + FB + HB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld = 1'b0;
  logic [4:0] code0 = '0, code1 = '0, code2 = '0;
  logic signed [DW-1:0] smp = '0;
  logic signed [TW-1:0] term0, term1, term2, tap_sum;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  logic [4:0] mc [3];

  sdterm_gen #(.DW(DW), .FB(FB), .HB(HB), .SUM_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .ld(ld), .code0(code0), .code1(code1), .code2(code2),
    .smp(smp), .term0(term0), .term1(term1), .term2(term2), .tap_sum(tap_sum));

  always #10 clk = ~clk;

  // reference code registers
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc[0] = 5'b01111; mc[1] = 5'b01111; mc[2] = 5'b01111;
    end else if (ld) begin
      mc[0] = code0; mc[1] = code1; mc[2] = code2;
    end
  end

  function automatic int ref_term(int x, logic [4:0] c);
    int v;
    if (c[3:0] == 4'hF) return 0;
    v = (x * (1 << FB)) >>> c[3:0];
    return c[4] ? -v : v;
  endfunction

  function automatic string code_tag(logic [4:0] c);
    if (c[3:0] == 4'hF) return "R4";
    return c[4] ? "R3" : "R2";
  endfunction

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    int e [3];
    int got [3];
    got[0] = int'(term0); got[1] = int'(term1); got[2] = int'(term2);
    for (int i = 0; i < 3; i++) begin
      e[i] = ref_term(int'(smp), mc[i]);
      check($sformatf("%s/%s/R8 lane%0d code=%b smp=%0d", cur_req, code_tag(mc[i]), i, mc[i], smp),
            got[i], e[i]);
    end
    check($sformatf("%s/R7 sum", cur_req), int'(tap_sum), e[0] + e[1] + e[2]);
  end

  task automatic drive(logic l, logic [4:0] a, logic [4:0] b, logic [4:0] c, int x);
    @(negedge clk);
    #1;
    ld = l; code0 = a; code1 = b; code2 = c; smp = DW'(x);
  endtask

  function automatic logic [4:0] pick_code();
    case ($urandom_range(0, 7))
      0: return 5'b01111;
      1: return 5'b11111;
      2: return 5'b00000;
      3: return 5'b10000;
      4: return {$urandom_range(0, 1) == 1, 4'd14};
      default: return {$urandom_range(0, 1) == 1, 4'($urandom_range(0, 14))};
    endcase
  endfunction

  function automatic int pick_smp();
    case ($urandom_range(0, 5))
      0: return -(1 << (DW - 1));
      1: return (1 << (DW - 1)) - 1;
      2: return -1;
      3: return 0;
      default: return $urandom_range(0, (1 << DW) - 1) - (1 << (DW - 1));
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    drive(1'b0, 5'b00000, 5'b10000, 5'b00011, 300);
    drive(1'b0, 5'b00000, 5'b10000, 5'b00011, -300);
    @(negedge clk); #1; rst_n = 1'b1;
    drive(1'b0, 5'b00001, 5'b00001, 5'b00001, 100);
    drive(1'b0, 5'b00001, 5'b00001, 5'b00001, 100);
    // R6: distinct codes per lane, one strobe
    cur_req = "R6";
    drive(1'b1, 5'b00000, 5'b10000, 5'b11111, -512);
    drive(1'b0, 5'b00000, 5'b10000, 5'b11111, 511);
    drive(1'b1, 5'b01110, 5'b11110, 5'b01111, -512);
    drive(1'b0, 5'b00000, 5'b00000, 5'b00000, -1);
    // R5: code inputs change while strobe low
    cur_req = "R5";
    for (int i = 0; i < 20; i++) drive(1'b0, pick_code(), pick_code(), pick_code(), pick_smp());
    // R2/R3/R4 corner sweep: every shift, both signs
    cur_req = "R2R3";
    for (int k = 0; k < 16; k++) begin
      drive(1'b1, {1'b0, 4'(k)}, {1'b1, 4'(k)}, {1'b1, 4'(k)}, -512);
      drive(1'b0, 5'b0, 5'b0, 5'b0, 511);
      drive(1'b0, 5'b0, 5'b0, 5'b0, -3);
    end
    // random mix
    cur_req = "RND";
    for (int i = 0; i < 3000; i++)
      drive(($urandom_range(0, 3) == 0), pick_code(), pick_code(), pick_code(), pick_smp());
    // reset mid-run returns to zero codes
    cur_req = "R1";
    @(negedge clk); #1; rst_n = 1'b0;
    drive(1'b1, 5'b00000, 5'b00000, 5'b00000, 200);
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule